// File: doc/BRIEF.md
# Bus-to-Local DMA Address Map

This block lets DMA masters on a shared 22-bit I/O bus reach a processor's private 24-bit local memory. It holds one map entry for each 512-byte bus page. Each entry has a valid flag and a 15-bit local page-frame number. When a bus slave cycle is presented, the block looks up the entry selected by the upper bus address bits. One clock later it either raises a reply strobe with the translated local address, or it stays silent so that some other responder on the bus can own that address.

A single global external-access enable sits above all entries. While it is clear, the block never replies, whatever the entries hold. Local software programs the entries through a simple write port. It uses the same port to clear entries during a boot-time sweep, and a separate strobe loads the global enable. The PFN storage is a plain synchronous memory so that it can map onto block RAM. The valid flags are kept in flops so that reset can clear them all at once.

Top module: `dma_amap`

## Requirements
- R1: On a reply, `rsp_addr[23:9]` equals the page-frame number stored in the entry selected by `bus_addr[21:9]`.
- R2: A lookup of an entry whose valid flag is clear gives `rsp_hit`=0 and `rsp_addr`=0 one cycle later, including after the entry is cleared by a write with `cfg_valid`=0.
- R3: While the global enable is clear, a lookup of any entry gives `rsp_hit`=0 and `rsp_addr`=0 one cycle later.
- R4: When `cfg_we`=1, the entry at `cfg_idx` takes `cfg_valid` and `cfg_pfn` at the clock edge. When `cfg_en_we`=1, the global enable takes `cfg_en` at the clock edge.
- R5: On a reply, `rsp_addr[8:0]` equals `bus_addr[8:0]` of the lookup unchanged.
- R6: The reply for a lookup presented with `bus_cyc`=1 in cycle t appears in cycle t+1. A cycle with `bus_cyc`=0 gives `rsp_hit`=0 in the next cycle, so back-to-back lookups give one strobe per cycle.
- R7: A write to an entry in the same cycle as a lookup of that entry returns the old valid flag and the old PFN to the lookup. The new contents take effect from the next lookup.
- R8: Synchronous reset `rst` clears every valid flag, the global enable and `rsp_hit`.
- R9: A write to the global enable in the same cycle as a lookup does not affect that lookup. The lookup uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Map entry write strobe |
| cfg_idx | input | 13 | Entry index to write |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_pfn | input | 15 | Local page-frame number written to the entry |
| cfg_en_we | input | 1 | Global enable write strobe |
| cfg_en | input | 1 | Value loaded into the global enable |
| bus_cyc | input | 1 | Bus slave cycle present this clock |
| bus_addr | input | 22 | Bus address of the slave cycle |
| rsp_hit | output | 1 | Reply strobe, one cycle after the lookup |
| rsp_addr | output | 24 | Translated local address; zero when there is no reply |

## Verification
On every cycle the assertions check three things: the reply never appears without a lookup in the cycle before, a lookup made while the global enable is clear stays silent, and the page offset of a reply matches the bus address that caused it. Reset silence is also checked on every cycle. Only the bench scenarios can show the translated page frames, the silence of cleared entries, and the read-old ordering of writes to an entry or to the enable in the same cycle as a lookup. The bench also shows that reset clears both the stored valid flags and the enable.

// File: rtl/dma_amap_pkg.sv
package dma_amap_pkg;
  localparam int unsigned BUS_AW_DEF    = 22;
  localparam int unsigned LOC_AW_DEF    = 24;
  localparam int unsigned PAGE_BITS_DEF = 9;

  typedef enum logic [0:0] {
    MAP_MISS = 1'b0,
    MAP_HIT  = 1'b1
  } map_result_e;
endpackage

// File: rtl/amap_pfn_ram.sv
module amap_pfn_ram #(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned DW    = 15,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [DW-1:0]    wd,
  input  logic             re,
  input  logic [IDX_W-1:0] ra,
  output logic [DW-1:0]    rd
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual port, read-first: a same-address write lands after the read.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/amap_valid_bank.sv
module amap_valid_bank
  import dma_amap_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic             wv,
  input  logic             lk_cyc,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output map_result_e      hit_q
);
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      hit_q <= MAP_MISS;
    end else begin
      if (we) vld[wa] <= wv;
      hit_q <= (lk_cyc && lk_en && vld[lk_idx]) ? MAP_HIT : MAP_MISS;
    end
  end

  // R8: a reset cycle leaves the strobe low on the following cycle
  p_reset_silent_r8: assert property (@(posedge clk) rst |=> (hit_q == MAP_MISS))
    else $error("R8 hit after reset");
endmodule

// File: rtl/dma_amap.sv
module dma_amap
  import dma_amap_pkg::*;
#(
  parameter int unsigned BUS_AW    = BUS_AW_DEF,
  parameter int unsigned LOC_AW    = LOC_AW_DEF,
  parameter int unsigned PAGE_BITS = PAGE_BITS_DEF,
  localparam int unsigned IDX_W = BUS_AW - PAGE_BITS,
  localparam int unsigned PFN_W = LOC_AW - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [PFN_W-1:0]  cfg_pfn,
  input  logic              cfg_en_we,
  input  logic              cfg_en,
  input  logic              bus_cyc,
  input  logic [BUS_AW-1:0] bus_addr,
  output logic              rsp_hit,
  output logic [LOC_AW-1:0] rsp_addr
);
  logic                 glb_en_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [PFN_W-1:0]     pfn_rd;
  map_result_e          hit_res;
  logic [IDX_W-1:0]     lk_idx;

  assign lk_idx = bus_addr[BUS_AW-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en_q <= 1'b0;
      off_q    <= '0;
    end else begin
      if (cfg_en_we) glb_en_q <= cfg_en;
      if (bus_cyc) off_q <= bus_addr[PAGE_BITS-1:0];
    end
  end

  amap_valid_bank #(.IDX_W(IDX_W)) u_vld (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wa     (cfg_idx),
    .wv     (cfg_valid),
    .lk_cyc (bus_cyc),
    .lk_en  (glb_en_q),
    .lk_idx (lk_idx),
    .hit_q  (hit_res)
  );

  amap_pfn_ram #(.IDX_W(IDX_W), .DW(PFN_W)) u_pfn (
    .clk (clk),
    .we  (cfg_we),
    .wa  (cfg_idx),
    .wd  (cfg_pfn),
    .re  (bus_cyc),
    .ra  (lk_idx),
    .rd  (pfn_rd)
  );

  assign rsp_hit  = (hit_res == MAP_HIT);
  assign rsp_addr = rsp_hit ? {pfn_rd, off_q} : '0;

  // R6: no reply without a lookup in the previous cycle
  p_no_orphan_reply_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_cyc |=> !rsp_hit) else $error("R6 orphan reply");

  // R3: a lookup under a cleared global enable stays silent
  p_disabled_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !glb_en_q) |=> (!rsp_hit && rsp_addr == '0)) else $error("R3 reply while disabled");

  // R5: the page offset of a reply is the offset of the lookup
  p_offset_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !rst) |=> (!rsp_hit || rsp_addr[PAGE_BITS-1:0] == $past(bus_addr[PAGE_BITS-1:0])))
    else $error("R5 offset changed");
endmodule

// File: tb/tb_dma_amap.sv
module tb_dma_amap;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_valid, cfg_en_we, cfg_en, bus_cyc;
  logic [12:0] cfg_idx;
  logic [14:0] cfg_pfn;
  logic [21:0] bus_addr;
  logic        rsp_hit;
  logic [23:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dma_amap dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_pfn(cfg_pfn), .cfg_en_we(cfg_en_we), .cfg_en(cfg_en), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
  );

  // {bus address, expected hit, expected local address}
  localparam logic [46:0] VEC [5] = '{
    {22'h0001FF, 1'b1, {15'h7FFF, 9'h1FF}},
    {22'h3FFE00, 1'b1, {15'h1234, 9'h000}},
    {22'h000AA5, 1'b1, {15'h0ABC, 9'h0A5}},
    {22'h000C10, 1'b0, 24'h000000},
    {22'h3FFFFF, 1'b1, {15'h1234, 9'h1FF}}
  };

  task automatic check(input string tag, input logic eh, input logic [23:0] ea);
    checks++;
    if (rsp_hit !== eh || rsp_addr !== ea) begin
      errors++;
      $display("FAIL %s: hit=%0b addr=%06h expected hit=%0b addr=%06h", tag, rsp_hit, rsp_addr, eh, ea);
    end
  endtask

  task automatic wr(input logic [12:0] i, input logic v, input logic [14:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_valid = v; cfg_pfn = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_en(input logic e);
    @(negedge clk);
    cfg_en_we = 1'b1; cfg_en = e;
    @(negedge clk);
    cfg_en_we = 1'b0;
  endtask

  task automatic look(input logic [21:0] a);
    @(negedge clk);
    bus_cyc = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_cyc = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_pfn = 0;
    cfg_en_we = 0; cfg_en = 0; bus_cyc = 0; bus_addr = 0;
    repeat (3) @(negedge clk);
    check("R8 reset state", 1'b0, 24'h0);
    rst = 1'b0;

    // R4 programming
    wr(13'd0, 1'b1, 15'h7FFF);
    wr(13'd8191, 1'b1, 15'h1234);
    wr(13'd5, 1'b1, 15'h0ABC);
    set_en(1'b1);

    // R1 R2 R5 table walk
    for (int k = 0; k < 5; k++) begin
      look(VEC[k][46:25]);
      check("R1/R5 table", VEC[k][24], VEC[k][23:0]);
    end

    // R3 global enable clear
    set_en(1'b0);
    look(22'h0001FF);
    check("R3 disabled", 1'b0, 24'h0);
    set_en(1'b1);
    look(22'h0001FF);
    check("R4 re-enabled", 1'b1, 24'hFFFFFF);

    // R9 enable write concurrent with lookup
    @(negedge clk);
    cfg_en_we = 1'b1; cfg_en = 1'b0; bus_cyc = 1'b1; bus_addr = 22'h000010;
    @(negedge clk);
    cfg_en_we = 1'b0; bus_cyc = 1'b0;
    check("R9 old enable", 1'b1, {15'h7FFF, 9'h010});
    look(22'h000010);
    check("R9 new enable", 1'b0, 24'h0);
    set_en(1'b1);

    // R7 PFN write concurrent with lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 13'd5; cfg_valid = 1'b1; cfg_pfn = 15'h0001;
    bus_cyc = 1'b1; bus_addr = 22'h000AA5;
    @(negedge clk);
    cfg_we = 1'b0; bus_cyc = 1'b0;
    check("R7 old pfn", 1'b1, 24'h1578A5);
    look(22'h000AA5);
    check("R7 new pfn", 1'b1, 24'h0002A5);

    // R2 clear an entry
    wr(13'd5, 1'b0, 15'h0001);
    look(22'h000AA5);
    check("R2 cleared entry", 1'b0, 24'h0);

    // R7 valid set concurrent with lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 13'd6; cfg_valid = 1'b1; cfg_pfn = 15'h0002;
    bus_cyc = 1'b1; bus_addr = 22'h000C10;
    @(negedge clk);
    cfg_we = 1'b0; bus_cyc = 1'b0;
    check("R7 old valid", 1'b0, 24'h0);
    look(22'h000C10);
    check("R7 new valid", 1'b1, 24'h000410);

    // R6 back-to-back lookups
    @(negedge clk);
    bus_cyc = 1'b1; bus_addr = 22'h000003;
    @(negedge clk);
    bus_addr = 22'h3FFE07;
    check("R6 first of pair", 1'b1, 24'hFFFE03);
    @(negedge clk);
    bus_cyc = 1'b0;
    check("R6 second of pair", 1'b1, {15'h1234, 9'h007});
    @(negedge clk);
    check("R6 strobe drops", 1'b0, 24'h0);

    // R8 reset mid-run clears valid flags and enable
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    set_en(1'b1);
    look(22'h0001FF);
    check("R8 valid cleared", 1'b0, 24'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(13'd0, 1'b1, 15'h0003);
    look(22'h000001);
    check("R8 enable cleared", 1'b0, 24'h0);
    set_en(1'b1);
    look(22'h000001);
    check("R4 after reset", 1'b1, 24'h000601);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule